// File: doc/BRIEF.md
# Two-Channel Feedback Separation Forward Array

This block produces the two separated output samples of a two-input, two-output convolutive feedback separation network. Each accepted pair of mixture samples travels down a linear chain of per-tap processing elements. Each element adds to a running partial cost the cross-weighted contribution of the block's own past outputs. A closing stage then merges the current mixtures, the zero-lag cross weights and the accumulated costs into the new outputs.

Cross weights for every lag, together with a precomputed reciprocal of the zero-lag normalisation term, are written through a simple tap-indexed load port. Weight learning takes place elsewhere and only writes its results into this block. Samples are signed integers. Weights and the reciprocal are signed fixed point with `FB` fractional bits. Every product is rounded and clamped back to its target width. A sample is accepted only when the chain is idle, and the result appears after a fixed latency. That latency is one cycle per tap plus one cycle for the closing stage.

Top module: `fbsep_forward`

## Requirements
- R1: Reset clears every weight, the reciprocal, the partial costs, the output history and both outputs. With no weights loaded after reset, any sample yields y1 = y2 = 0.
- R2: A sample presented with `inValid` high while the block is idle produces exactly one `outValid` pulse, TAPS+1 cycles later (cycle k in, cycle k+TAPS+1 out).
- R3: While a sample is in flight (the TAPS cycles after acceptance), `inValid` is ignored: it yields no extra output pulse and does not change the result.
- R4: With every cross weight zero and a reciprocal of 1.0 (value 2^FB), the outputs equal the inputs: y1 = x1 and y2 = x2.
- R5: The closing stage forms y1 = recip·(x1 + w12[0]·x2 + f1) and y2 = recip·(x2 + w21[0]·x1 + f2). Here f1 and f2 are the costs after the last tap.
- R6: For each lag p in 1..TAPS, the channel-1 cost grows by w12[p]·y2(t-p) + c·y1(t-p), where c = w12[0]·w21[p]. Channel 2 mirrors this with indices 1 and 2 swapped. The cost entering lag 1 is zero.
- R7: Every product and every sum is clamped to the signed range of its width: DW for samples and costs, WW for the coupled weight c.
- R8: Each fixed-point product a·b is scaled as floor((a·b + 2^(FB-1)) / 2^FB), which rounds halves toward plus infinity.
- R9: A write with `wrEn` high stores `wr12` and `wr21` at lag `wrTap` when `wrTap` ≤ TAPS. The reciprocal is latched only on a write to lag 0. Writes to lags above TAPS change nothing.
- R10: The history holds the last TAPS outputs of each channel. The newest entry is lag 1, and older outputs fall out.
- R11: Between output pulses, y1 and y2 hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Mixture sample pair present |
| x1In | input | DW | Mixture sample, channel 1 (signed) |
| x2In | input | DW | Mixture sample, channel 2 (signed) |
| wrEn | input | 1 | Weight write strobe |
| wrTap | input | TW | Lag index of the write |
| wr12 | input | WW | Cross weight 1←2 for that lag (signed, FB fraction bits) |
| wr21 | input | WW | Cross weight 2←1 for that lag (signed, FB fraction bits) |
| wrRecip | input | WW | Normalising reciprocal, latched on lag-0 writes |
| outValid | output | 1 | Output pair valid, one-cycle pulse |
| y1Out | output | DW | Separated output, channel 1 (signed) |
| y2Out | output | DW | Separated output, channel 2 (signed) |

## Verification
Outputs are fed back, so a corrupted partial cost, history entry or weight does not just spoil one sample. It shows as a wrong y value at the next `outValid` pulse and then keeps returning through the history for up to TAPS further samples. The bench therefore compares every output cycle against a behavioural model over long sample runs with nonzero lags. A wrong control state shows at once as a misplaced or missing pulse, or as outputs that move between pulses. Rounding and clamping faults only appear at particular values, so directed samples place products exactly at half-steps and sums beyond full scale.

// File: rtl/fbsep_pkg.sv
package fbsep_pkg;
  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic accept;   // sample taken this edge
    logic finish;   // closing stage writes outputs this edge
  } fbsep_strobe_t;
endpackage

// File: rtl/fbsep_ctrl.sv
module fbsep_ctrl
  import fbsep_pkg::*;
#(
  parameter int TAPS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  output fbsep_strobe_t stb
);
  localparam int CW = $clog2(TAPS + 1);

  logic [CW-1:0] stage;

  always_comb begin
    stb.accept = inValid && (stage == '0);
    stb.finish = (stage == CW'(TAPS));
  end

  always_ff @(posedge clk) begin
    if (rst) stage <= '0;
    else if (stb.accept) stage <= CW'(1);
    else if (stb.finish) stage <= '0;
    else if (stage != '0) stage <= stage + CW'(1);
  end
endmodule

// File: rtl/fbsep_datapath.sv
module fbsep_datapath
  import fbsep_pkg::*;
#(
  parameter int DW   = 16,
  parameter int WW   = 16,
  parameter int FB   = 12,
  parameter int TAPS = 4,
  parameter int TW   = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  fbsep_strobe_t        stb,
  input  logic signed [DW-1:0] x1In,
  input  logic signed [DW-1:0] x2In,
  input  logic                 wrEn,
  input  logic [TW-1:0]        wrTap,
  input  logic signed [WW-1:0] wr12,
  input  logic signed [WW-1:0] wr21,
  input  logic signed [WW-1:0] wrRecip,
  output logic                 outValid,
  output logic signed [DW-1:0] y1Out,
  output logic signed [DW-1:0] y2Out
);
  localparam int AW = DW + 2 * WW + 2;
  localparam logic signed [AW-1:0] HALF = AW'(1) <<< (FB - 1);
  localparam logic signed [AW-1:0] MAXD = (AW'(1) <<< (DW - 1)) - AW'(1);
  localparam logic signed [AW-1:0] MIND = ~MAXD;
  localparam logic signed [AW-1:0] MAXW = (AW'(1) <<< (WW - 1)) - AW'(1);
  localparam logic signed [AW-1:0] MINW = ~MAXW;

  function automatic logic signed [AW-1:0] sxD(input logic signed [DW-1:0] v);
    return $signed({{(AW-DW){v[DW-1]}}, v});
  endfunction

  function automatic logic signed [AW-1:0] sxW(input logic signed [WW-1:0] v);
    return $signed({{(AW-WW){v[WW-1]}}, v});
  endfunction

  function automatic logic signed [AW-1:0] clampTo(input logic signed [AW-1:0] v,
                                                   input logic signed [AW-1:0] hi,
                                                   input logic signed [AW-1:0] lo);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // fixed-point product, half-up rounding
  function automatic logic signed [AW-1:0] scaleMul(input logic signed [AW-1:0] a,
                                                    input logic signed [AW-1:0] b);
    logic signed [AW-1:0] prod;
    prod = a * b;
    return (prod + HALF) >>> FB;
  endfunction

  function automatic logic signed [DW-1:0] mulD(input logic signed [WW-1:0] a,
                                                input logic signed [DW-1:0] b);
    logic signed [AW-1:0] c;
    c = clampTo(scaleMul(sxW(a), sxD(b)), MAXD, MIND);
    return c[DW-1:0];
  endfunction

  function automatic logic signed [WW-1:0] mulW(input logic signed [WW-1:0] a,
                                                input logic signed [WW-1:0] b);
    logic signed [AW-1:0] c;
    c = clampTo(scaleMul(sxW(a), sxW(b)), MAXW, MINW);
    return c[WW-1:0];
  endfunction

  function automatic logic signed [DW-1:0] narrowD(input logic signed [AW-1:0] v);
    logic signed [AW-1:0] c;
    c = clampTo(v, MAXD, MIND);
    return c[DW-1:0];
  endfunction

  logic signed [WW-1:0] w12 [0:TAPS];
  logic signed [WW-1:0] w21 [0:TAPS];
  logic signed [WW-1:0] recip;
  logic signed [DW-1:0] hist1 [1:TAPS];
  logic signed [DW-1:0] hist2 [1:TAPS];
  logic signed [DW-1:0] xa1, xa2;

  // weight store
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p <= TAPS; p++) begin
        w12[p] <= '0;
        w21[p] <= '0;
      end
      recip <= '0;
    end else if (wrEn && (wrTap <= TW'(TAPS))) begin
      w12[wrTap] <= wr12;
      w21[wrTap] <= wr21;
      if (wrTap == '0) recip <= wrRecip;
    end
  end

  // per-lag processing elements, cost ripples one lag per cycle
  for (genvar p = 1; p <= TAPS; p++) begin : g_pe
    logic signed [DW-1:0] prevA, prevB, costA, costB;
    logic signed [WW-1:0] coupA, coupB;
    logic signed [AW-1:0] sumA, sumB;

    if (p == 1) begin : g_head
      assign prevA = '0;
      assign prevB = '0;
    end else begin : g_link
      assign prevA = g_pe[p-1].costA;
      assign prevB = g_pe[p-1].costB;
    end

    always_comb begin
      coupA = mulW(w12[0], w21[p]);
      coupB = mulW(w21[0], w12[p]);
      sumA  = sxD(prevA) + sxD(mulD(w12[p], hist2[p])) + sxD(mulD(coupA, hist1[p]));
      sumB  = sxD(prevB) + sxD(mulD(w21[p], hist1[p])) + sxD(mulD(coupB, hist2[p]));
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        costA <= '0;
        costB <= '0;
      end else begin
        costA <= narrowD(sumA);
        costB <= narrowD(sumB);
      end
    end
  end

  // closing stage
  logic signed [DW-1:0] s1, s2, y1Next, y2Next;
  always_comb begin
    s1 = narrowD(sxD(xa1) + sxD(mulD(w12[0], xa2)) + sxD(g_pe[TAPS].costA));
    s2 = narrowD(sxD(xa2) + sxD(mulD(w21[0], xa1)) + sxD(g_pe[TAPS].costB));
    y1Next = mulD(recip, s1);
    y2Next = mulD(recip, s2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xa1      <= '0;
      xa2      <= '0;
      y1Out    <= '0;
      y2Out    <= '0;
      outValid <= 1'b0;
      for (int p = 1; p <= TAPS; p++) begin
        hist1[p] <= '0;
        hist2[p] <= '0;
      end
    end else begin
      outValid <= stb.finish;
      if (stb.accept) begin
        xa1 <= x1In;
        xa2 <= x2In;
      end
      if (stb.finish) begin
        y1Out    <= y1Next;
        y2Out    <= y2Next;
        hist1[1] <= y1Next;
        hist2[1] <= y2Next;
        for (int p = 2; p <= TAPS; p++) begin
          hist1[p] <= hist1[p-1];
          hist2[p] <= hist2[p-1];
        end
      end
    end
  end
endmodule

// File: rtl/fbsep_forward.sv
module fbsep_forward
  import fbsep_pkg::*;
#(
  parameter int DW   = 16,
  parameter int WW   = 16,
  parameter int FB   = 12,
  parameter int TAPS = 4,
  localparam int TW  = $clog2(TAPS + 2)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  input  logic signed [DW-1:0] x1In,
  input  logic signed [DW-1:0] x2In,
  input  logic                 wrEn,
  input  logic [TW-1:0]        wrTap,
  input  logic signed [WW-1:0] wr12,
  input  logic signed [WW-1:0] wr21,
  input  logic signed [WW-1:0] wrRecip,
  output logic                 outValid,
  output logic signed [DW-1:0] y1Out,
  output logic signed [DW-1:0] y2Out
);
  fbsep_strobe_t stb;

  fbsep_ctrl #(.TAPS(TAPS)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .stb(stb)
  );

  fbsep_datapath #(.DW(DW), .WW(WW), .FB(FB), .TAPS(TAPS), .TW(TW)) u_dp (
    .clk(clk), .rst(rst), .stb(stb),
    .x1In(x1In), .x2In(x2In),
    .wrEn(wrEn), .wrTap(wrTap), .wr12(wr12), .wr21(wr21), .wrRecip(wrRecip),
    .outValid(outValid), .y1Out(y1Out), .y2Out(y2Out)
  );
endmodule

// File: rtl/fbsep_forward_chk.sv
module fbsep_forward_chk #(
  parameter int DW   = 16,
  parameter int TAPS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 inValid,
  input logic                 outValid,
  input logic signed [DW-1:0] y1,
  input logic signed [DW-1:0] y2
);
  localparam int LAT = TAPS + 1;
  localparam int CW  = $clog2(TAPS + 2);

  // cycles since the sample in flight was taken (0 = idle)
  logic [CW-1:0] track;
  always_ff @(posedge clk) begin
    if (rst) track <= '0;
    else if (track == '0 || track == CW'(LAT)) track <= inValid ? CW'(1) : '0;
    else track <= track + CW'(1);
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!outValid && y1 == '0 && y2 == '0));

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);

  a_r2_latency_hit: assert property (@(posedge clk) disable iff (rst)
    (track == CW'(LAT)) |-> outValid);

  a_r3_no_stray_output: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (track == CW'(LAT)));

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> ($stable(y1) && $stable(y2)));
endmodule

bind fbsep_forward fbsep_forward_chk #(.DW(DW), .TAPS(TAPS)) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .outValid(outValid),
  .y1(y1Out), .y2(y2Out)
);

// File: tb/fbsep_forward_test.sv
module fbsep_forward_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16, WW = 16, FB = 12, TAPS = 4;
  localparam int TW = $clog2(TAPS + 2);

  logic clk = 1'b0, rst = 1'b1;
  logic inValid = 1'b0, wrEn = 1'b0;
  logic signed [DW-1:0] x1In = '0, x2In = '0;
  logic [TW-1:0] wrTap = '0;
  logic signed [WW-1:0] wr12 = '0, wr21 = '0, wrRecip = '0;
  logic outValid;
  logic signed [DW-1:0] y1Out, y2Out;

  fbsep_forward #(.DW(DW), .WW(WW), .FB(FB), .TAPS(TAPS)) uut (
    .clk(clk), .rst(rst), .inValid(inValid), .x1In(x1In), .x2In(x2In),
    .wrEn(wrEn), .wrTap(wrTap), .wr12(wr12), .wr21(wr21), .wrRecip(wrRecip),
    .outValid(outValid), .y1Out(y1Out), .y2Out(y2Out)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, pulses = 0;
  string phase = "R4";

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  longint mw12 [0:TAPS], mw21 [0:TAPS], mrecip;
  longint mh1[$], mh2[$];
  longint expY1, expY2, pend1, pend2;
  bit expValid;
  int cd;

  function automatic longint sat(input longint v, input int bits);
    longint hi = (longint'(1) <<< (bits - 1)) - 1;
    if (v > hi) return hi;
    if (v < -hi - 1) return -hi - 1;
    return v;
  endfunction

  function automatic longint rmul(input longint a, input longint b);
    return (a * b + (longint'(1) <<< (FB - 1))) >>> FB;
  endfunction

  task automatic modelCompute(input longint a1, input longint a2);
    longint f1 = 0, f2 = 0, c1, c2, s1, s2;
    for (int p = 1; p <= TAPS; p++) begin
      c1 = sat(rmul(mw12[0], mw21[p]), WW);
      c2 = sat(rmul(mw21[0], mw12[p]), WW);
      f1 = sat(f1 + sat(rmul(mw12[p], mh2[p-1]), DW) + sat(rmul(c1, mh1[p-1]), DW), DW);
      f2 = sat(f2 + sat(rmul(mw21[p], mh1[p-1]), DW) + sat(rmul(c2, mh2[p-1]), DW), DW);
    end
    s1 = sat(a1 + sat(rmul(mw12[0], a2), DW) + f1, DW);
    s2 = sat(a2 + sat(rmul(mw21[0], a1), DW) + f2, DW);
    pend1 = sat(rmul(mrecip, s1), DW);
    pend2 = sat(rmul(mrecip, s2), DW);
  endtask

  always @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p <= TAPS; p++) begin mw12[p] = 0; mw21[p] = 0; end
      mrecip = 0; expY1 = 0; expY2 = 0; expValid = 0; cd = 0;
      mh1.delete(); mh2.delete();
      for (int p = 0; p < TAPS; p++) begin mh1.push_back(0); mh2.push_back(0); end
    end else begin
      bit acc;
      acc = inValid && (cd == 0);
      expValid = 0;
      if (cd > 0) begin
        cd--;
        if (cd == 0) begin
          expValid = 1; expY1 = pend1; expY2 = pend2;
          mh1.push_front(pend1); mh2.push_front(pend2);
          void'(mh1.pop_back()); void'(mh2.pop_back());
        end
      end
      if (acc) begin
        modelCompute(longint'(x1In), longint'(x2In));
        cd = TAPS;
      end
      if (wrEn && wrTap <= TAPS) begin
        mw12[wrTap] = longint'(wr12);
        mw21[wrTap] = longint'(wr21);
        if (wrTap == 0) mrecip = longint'(wrRecip);
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check(outValid == expValid, "R2 pulse", longint'(outValid), longint'(expValid));
      check(longint'(y1Out) == expY1, expValid ? phase : "R11 hold y1", longint'(y1Out), expY1);
      check(longint'(y2Out) == expY2, expValid ? phase : "R11 hold y2", longint'(y2Out), expY2);
    end
  end

  always @(posedge clk) if (outValid) pulses++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected under 50000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic writeW(input int tap, input int a, input int b, input int r);
    @(negedge clk);
    wrEn = 1'b1; wrTap = TW'(tap); wr12 = WW'(a); wr21 = WW'(b); wrRecip = WW'(r);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic clearW();
    for (int t = 0; t <= TAPS; t++) writeW(t, 0, 0, 4096);
  endtask

  task automatic send(input int a, input int b);
    @(negedge clk);
    inValid = 1'b1; x1In = DW'(a); x2In = DW'(b);
    @(negedge clk);
    inValid = 1'b0;
    repeat (TAPS + 1) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0, "R1 reset valid", longint'(outValid), 0);
    check(y1Out == '0 && y2Out == '0, "R1 reset outputs", longint'(y1Out), 0);

    phase = "R1";
    send(1234, -99);
    check(y1Out == '0 && y2Out == '0, "R1 cleared weights", longint'(y1Out), 0);

    phase = "R4";
    writeW(0, 0, 0, 4096);
    send(100, -200);
    check(y1Out == 100 && y2Out == -200, "R4 pass-through", longint'(y1Out), 100);
    send(32000, -5);
    check(y1Out == 32000 && y2Out == -5, "R4 pass-through", longint'(y1Out), 32000);

    // latency measured in cycles from the driving cycle
    begin
      int n = 0;
      @(negedge clk);
      inValid = 1'b1; x1In = 16'sd7; x2In = -16'sd7;
      do begin
        @(negedge clk);
        inValid = 1'b0;
        n++;
      end while (!outValid && n < 20);
      check(n == TAPS + 1, "R2 latency", n, TAPS + 1);
      repeat (2) @(negedge clk);
    end

    phase = "R5";
    writeW(0, 1024, -2048, 3641);
    send(1000, 2000);
    send(-1500, 700);
    send(8000, -8000);

    phase = "R6";
    writeW(1, 2048, -1024, 0);
    writeW(2, -512, 1536, 0);
    writeW(4, 300, -700, 0);
    for (int i = 0; i < 10; i++) send(400 * i - 1800, 2500 - 333 * i);

    phase = "R10";
    writeW(3, 900, 1200, 0);
    for (int i = 0; i < 8; i++) send((i % 2 == 0) ? 3000 : -2000, 150 * i);

    phase = "R3";
    begin
      int base;
      base = pulses;
      @(negedge clk);
      inValid = 1'b1; x1In = 16'sd555; x2In = -16'sd444;
      @(negedge clk);
      inValid = 1'b0;
      @(negedge clk);
      inValid = 1'b1; x1In = 16'sd9999; x2In = 16'sd9999;
      @(negedge clk);
      inValid = 1'b0;
      repeat (2 * TAPS + 4) @(negedge clk);
      check(pulses - base == 1, "R3 busy input ignored", pulses - base, 1);
    end

    phase = "R9";
    writeW(7, 9999, -9999, 100);
    writeW(3, 100, 200, 50);
    send(1200, -300);
    clearW();
    writeW(2, 0, 0, 1000);
    send(500, 600);
    check(y1Out == 500 && y2Out == 600, "R9 recip only on lag 0", longint'(y1Out), 500);

    phase = "R7";
    clearW();
    writeW(0, 4096, 0, 4096);
    send(30000, 30000);
    check(y1Out == 32767, "R7 clamp high", longint'(y1Out), 32767);
    check(y2Out == 30000, "R7 unclamped", longint'(y2Out), 30000);
    send(-30000, -30000);
    check(y1Out == -32768, "R7 clamp low", longint'(y1Out), -32768);

    phase = "R8";
    clearW();
    writeW(0, 0, 0, 2048);
    send(3, 5);
    check(y1Out == 2 && y2Out == 3, "R8 half rounds up", longint'(y1Out), 2);
    send(-3, -5);
    check(y1Out == -1, "R8 negative half", longint'(y1Out), -1);
    check(y2Out == -2, "R8 negative half", longint'(y2Out), -2);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule